// File: doc/BRIEF.md
# Load/Store Queue with Store-to-Load Forwarding

This block keeps memory operations in program order inside a circular buffer. Dispatch claims one slot per operation at the tail, and the slot index goes back to the pipeline. Retirement frees slots from the head. A store fills in its address and its data through two separate completion ports, either in the same cycle or in different cycles. Neither port writes the cache. The store reaches the cache write port only when it retires from the head.

A load presents its slot index and word address. In the same cycle the address goes to the data-cache read port and into an associative search of the queue. The search looks only at stores that sit between the head and the load's own slot. Among those with a known, equal address, the youngest one wins.

One cycle later the block returns a response in one of three forms:
- the cache data, when no older store matched;
- the forwarded store data, when the winning store holds its data;
- a retry indication, when the winning store has its address but not yet its data.

A flush input carries a sequence number. It drops every slot whose sequence number is younger and pulls the tail back.

Top module: `lsq_fwd_queue`

## Requirements
- R1: After reset the queue is empty: `full` is 0, `alloc_idx` is 0, `ld_resp_valid` is 0 and `dc_wr_en` is 0.
- R2: A dispatch (`alloc_valid` without `flush_valid`) takes the slot shown on `alloc_idx`, and `alloc_idx` then advances by one modulo DEPTH. `full` is 1 exactly when DEPTH slots are occupied. A dispatch while `full` is 1 is ignored: `alloc_idx` and `full` keep their values.
- R3: Store address (`sta_*`) and store data (`std_*`) completions update only the queue slot. `dc_wr_en` stays 0 during and after them until a retire.
- R4: In a cycle with `ret_valid`, the head slot is freed. If the head slot is a store, `dc_wr_en` is 1 in that same cycle, with that store's address and data on `dc_wr_addr` and `dc_wr_data`. If the head slot is a load, `dc_wr_en` stays 0.
- R5: In a cycle with `ld_valid`, `dc_rd_en` is 1 and `dc_rd_addr` equals `ld_addr` in that same cycle.
- R6: In the cycle after a lookup, `ld_resp_valid` is 1. If no older store with a known, equal address exists, `ld_resp_fwd` and `ld_resp_retry` are 0 and `ld_resp_data` equals `dc_rd_data` in that response cycle.
- R7: When several older stores have an address equal to the load's, the youngest of them (the one closest to the load) is chosen. If it holds its data, the response has `ld_resp_fwd`=1 and that store's data.
- R8: Stores younger than the load, and older stores whose address is not yet known, take no part in the search.
- R9: Age is measured from the head pointer. A store in a higher-numbered slot is older than a load in a lower-numbered slot once the queue has wrapped.
- R10: If the chosen store has its address but not its data, the response has `ld_resp_retry`=1, `ld_resp_fwd`=0 and `ld_resp_data`=0.
- R11: A flush removes every occupied slot whose sequence number is younger than `flush_seq`. Younger means that (slot seq − `flush_seq`) mod 2^SW lies in 1 .. 2^(SW−1)−1. The tail moves to head plus the number of kept slots. A dispatch in the flush cycle is ignored. Removed stores never forward again, and a reused slot takes the new operation's type.
- R12: A flush and a retire in the same cycle both take effect. The head store is written to the cache, and occupancy equals the kept count minus one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_valid | input | 1 | Dispatch request for one slot |
| alloc_is_store | input | 1 | 1 = store, 0 = load |
| alloc_seq | input | SW | Sequence number of the dispatched operation |
| alloc_idx | output | $clog2(DEPTH) | Slot the next dispatch will take (tail) |
| full | output | 1 | No free slot |
| sta_valid | input | 1 | Store address completion |
| sta_idx | input | $clog2(DEPTH) | Slot of the completing store |
| sta_addr | input | AW | Store word address |
| std_valid | input | 1 | Store data completion |
| std_idx | input | $clog2(DEPTH) | Slot of the completing store |
| std_data | input | DW | Store data |
| ld_valid | input | 1 | Load lookup request |
| ld_idx | input | $clog2(DEPTH) | Slot of the load |
| ld_addr | input | AW | Load word address |
| dc_rd_en | output | 1 | Cache read request |
| dc_rd_addr | output | AW | Cache read address |
| dc_rd_data | input | DW | Cache read data, valid one cycle after the request |
| ld_resp_valid | output | 1 | Load response valid |
| ld_resp_fwd | output | 1 | Data comes from a queued store |
| ld_resp_retry | output | 1 | Matching store lacks data; load must retry |
| ld_resp_data | output | DW | Load result |
| ret_valid | input | 1 | Retire the head slot |
| dc_wr_en | output | 1 | Cache write of a retiring store |
| dc_wr_addr | output | AW | Cache write address |
| dc_wr_data | output | DW | Cache write data |
| flush_valid | input | 1 | Flush request |
| flush_seq | input | SW | Slots younger than this are removed |

## Verification
The bench builds the queue with DEPTH=4, AW=16, DW=16 and SW=6. With four slots, a handful of dispatches fill the queue and carry the head and tail across the wrap point, so a load can sit in a lower slot than the stores it must see. With six-bit sequence numbers, the bench can pick values 62, 63 and 0 in one window. This exercises the modulo age comparison of the flush next to the slot-index wrap.

// File: rtl/lsq_pkg.sv
package lsq_pkg;

  typedef enum logic [1:0] {
    RESP_CACHE = 2'd0,
    RESP_FWD   = 2'd1,
    RESP_RETRY = 2'd2
  } lsq_resp_e;

  // distance from a reference slot to a slot, walking forward around the ring
  function automatic int unsigned ring_dist(input int unsigned from_idx,
                                            input int unsigned to_idx,
                                            input int unsigned depth);
    return (to_idx + depth - from_idx) % depth;
  endfunction

  // 1 when sequence number a was issued after b, modulo 2^width
  function automatic logic seq_after(input int unsigned a,
                                     input int unsigned b,
                                     input int unsigned width);
    int unsigned mask;
    int unsigned diff;
    mask = (width >= 32) ? 32'hFFFF_FFFF : ((32'd1 << width) - 32'd1);
    diff = (a - b) & mask;
    return (diff != 32'd0) && (diff < (32'd1 << (width - 1)));
  endfunction

endpackage

// File: rtl/lsq_ptr_ctrl.sv
module lsq_ptr_ctrl #(
  parameter int DEPTH = 8,
  localparam int IW = $clog2(DEPTH),
  localparam int CW = IW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          alloc_valid,
  input  logic          ret_valid,
  input  logic          flush_valid,
  input  logic [CW-1:0] flush_keep,
  output logic          alloc_fire,
  output logic          ret_fire,
  output logic [IW-1:0] head,
  output logic [IW-1:0] tail,
  output logic [CW-1:0] count,
  output logic          full
);

  assign full       = (count == CW'(DEPTH));
  assign alloc_fire = alloc_valid && !full && !flush_valid;
  assign ret_fire   = ret_valid && (count != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head  <= '0;
      tail  <= '0;
      count <= '0;
    end else begin
      head <= head + IW'(ret_fire);
      if (flush_valid) begin
        tail  <= head + IW'(flush_keep);
        count <= flush_keep - CW'(ret_fire);
      end else begin
        tail  <= tail + IW'(alloc_fire);
        count <= count + CW'(alloc_fire) - CW'(ret_fire);
      end
    end
  end

  a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  a_r2_full_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (full && alloc_valid && !flush_valid) |=> $stable(tail));

  a_r4_retire_frees: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_fire && !alloc_fire && !flush_valid) |=> (count == $past(count) - CW'(1)));

  a_r12_flush_retire_head: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_valid && ret_fire) |=> (head == $past(head) + IW'(1)));

endmodule

// File: rtl/lsq_flush_scan.sv
module lsq_flush_scan #(
  parameter int DEPTH = 8,
  parameter int SW    = 8,
  localparam int IW = $clog2(DEPTH),
  localparam int CW = IW + 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     flush_valid,
  input  logic [IW-1:0]            head,
  input  logic [CW-1:0]            count,
  input  logic [DEPTH-1:0][SW-1:0] seq_q,
  input  logic [SW-1:0]            flush_seq,
  output logic [CW-1:0]            keep
);
  import lsq_pkg::*;

  logic [DEPTH-1:0] keep_bit;

  // position k counts from the head, so kept slots form a prefix
  for (genvar k = 0; k < DEPTH; k++) begin : g_pos
    logic [IW-1:0] slot;
    assign slot        = head + IW'(k);
    assign keep_bit[k] = (CW'(k) < count) &&
                         !seq_after(32'(seq_q[slot]), 32'(flush_seq), SW);
  end

  always_comb begin
    keep = '0;
    for (int k = 0; k < DEPTH; k++) keep = keep + CW'(keep_bit[k]);
  end

  a_r11_keep_bound: assert property (@(posedge clk) disable iff (!rst_n)
    flush_valid |-> (keep <= count));

endmodule

// File: rtl/lsq_fwd_search.sv
module lsq_fwd_search #(
  parameter int DEPTH = 8,
  parameter int AW    = 32,
  localparam int IW = $clog2(DEPTH),
  localparam int CW = IW + 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [IW-1:0]            head,
  input  logic [CW-1:0]            count,
  input  logic                     ld_valid,
  input  logic [IW-1:0]            ld_idx,
  input  logic [AW-1:0]            ld_addr,
  input  logic [DEPTH-1:0]         is_store,
  input  logic [DEPTH-1:0]         addr_known,
  input  logic [DEPTH-1:0][AW-1:0] addr_q,
  output logic                     hit,
  output logic [IW-1:0]            hit_idx
);
  import lsq_pkg::*;

  logic [IW-1:0]    ld_rel;
  logic [DEPTH-1:0] cand;

  assign ld_rel = IW'(ring_dist(32'(head), 32'(ld_idx), DEPTH));

  // candidate vector ordered by age: bit k is k slots after the head
  for (genvar k = 0; k < DEPTH; k++) begin : g_cand
    logic [IW-1:0] slot;
    assign slot    = head + IW'(k);
    assign cand[k] = (IW'(k) < ld_rel) && (k < DEPTH) && is_store[slot] &&
                     addr_known[slot] && (addr_q[slot] == ld_addr);
  end

  // youngest older match = highest age position
  always_comb begin
    hit     = 1'b0;
    hit_idx = '0;
    for (int k = 0; k < DEPTH; k++) begin
      if (cand[k]) begin
        hit     = 1'b1;
        hit_idx = head + IW'(k);
      end
    end
  end

  a_r9_hit_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && hit) |-> (CW'(ring_dist(32'(head), 32'(hit_idx), DEPTH)) < count));

  a_r8_hit_not_self: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && hit) |-> (hit_idx != ld_idx));

endmodule

// File: rtl/lsq_fwd_queue.sv
module lsq_fwd_queue #(
  parameter int DEPTH = 8,
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int SW    = 8,
  localparam int IW = $clog2(DEPTH),
  localparam int CW = IW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          alloc_valid,
  input  logic          alloc_is_store,
  input  logic [SW-1:0] alloc_seq,
  output logic [IW-1:0] alloc_idx,
  output logic          full,
  input  logic          sta_valid,
  input  logic [IW-1:0] sta_idx,
  input  logic [AW-1:0] sta_addr,
  input  logic          std_valid,
  input  logic [IW-1:0] std_idx,
  input  logic [DW-1:0] std_data,
  input  logic          ld_valid,
  input  logic [IW-1:0] ld_idx,
  input  logic [AW-1:0] ld_addr,
  output logic          dc_rd_en,
  output logic [AW-1:0] dc_rd_addr,
  input  logic [DW-1:0] dc_rd_data,
  output logic          ld_resp_valid,
  output logic          ld_resp_fwd,
  output logic          ld_resp_retry,
  output logic [DW-1:0] ld_resp_data,
  input  logic          ret_valid,
  output logic          dc_wr_en,
  output logic [AW-1:0] dc_wr_addr,
  output logic [DW-1:0] dc_wr_data,
  input  logic          flush_valid,
  input  logic [SW-1:0] flush_seq
);
  import lsq_pkg::*;

  // slot state
  logic [DEPTH-1:0]         st_q, ak_q, dk_q;
  logic [DEPTH-1:0][AW-1:0] addr_q;
  logic [DEPTH-1:0][DW-1:0] data_q;
  logic [DEPTH-1:0][SW-1:0] seq_q;

  // named internal events
  logic          alloc_fire, ret_fire;
  logic [IW-1:0] head, tail;
  logic [CW-1:0] count, flush_keep;
  logic          hit;
  logic [IW-1:0] hit_idx;

  lsq_ptr_ctrl #(.DEPTH(DEPTH)) u_ptr (
    .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid), .ret_valid(ret_valid),
    .flush_valid(flush_valid), .flush_keep(flush_keep), .alloc_fire(alloc_fire),
    .ret_fire(ret_fire), .head(head), .tail(tail), .count(count), .full(full)
  );

  lsq_flush_scan #(.DEPTH(DEPTH), .SW(SW)) u_flush (
    .clk(clk), .rst_n(rst_n), .flush_valid(flush_valid), .head(head),
    .count(count), .seq_q(seq_q), .flush_seq(flush_seq), .keep(flush_keep)
  );

  lsq_fwd_search #(.DEPTH(DEPTH), .AW(AW)) u_search (
    .clk(clk), .rst_n(rst_n), .head(head), .count(count), .ld_valid(ld_valid),
    .ld_idx(ld_idx), .ld_addr(ld_addr), .is_store(st_q), .addr_known(ak_q),
    .addr_q(addr_q), .hit(hit), .hit_idx(hit_idx)
  );

  assign alloc_idx = tail;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= '0;
      ak_q   <= '0;
      dk_q   <= '0;
      addr_q <= '0;
      data_q <= '0;
      seq_q  <= '0;
    end else begin
      if (alloc_fire) begin
        st_q[tail]  <= alloc_is_store;
        ak_q[tail]  <= 1'b0;
        dk_q[tail]  <= 1'b0;
        seq_q[tail] <= alloc_seq;
      end
      if (sta_valid) begin
        addr_q[sta_idx] <= sta_addr;
        ak_q[sta_idx]   <= 1'b1;
      end
      if (std_valid) begin
        data_q[std_idx] <= std_data;
        dk_q[std_idx]   <= 1'b1;
      end
    end
  end

  // cache read issued alongside the queue search
  assign dc_rd_en   = ld_valid;
  assign dc_rd_addr = ld_addr;

  // response stage
  logic          resp_v_q;
  lsq_resp_e     resp_kind_q;
  logic [DW-1:0] fwd_data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_v_q    <= 1'b0;
      resp_kind_q <= RESP_CACHE;
      fwd_data_q  <= '0;
    end else begin
      resp_v_q <= ld_valid;
      if (ld_valid) begin
        if (!hit)                resp_kind_q <= RESP_CACHE;
        else if (dk_q[hit_idx])  resp_kind_q <= RESP_FWD;
        else                     resp_kind_q <= RESP_RETRY;
        fwd_data_q <= data_q[hit_idx];
      end
    end
  end

  assign ld_resp_valid = resp_v_q;
  assign ld_resp_fwd   = resp_v_q && (resp_kind_q == RESP_FWD);
  assign ld_resp_retry = resp_v_q && (resp_kind_q == RESP_RETRY);

  always_comb begin
    if (!resp_v_q || resp_kind_q == RESP_RETRY) ld_resp_data = '0;
    else if (resp_kind_q == RESP_FWD)          ld_resp_data = fwd_data_q;
    else                                       ld_resp_data = dc_rd_data;
  end

  // retire drain to the cache write port
  assign dc_wr_en   = ret_fire && st_q[head];
  assign dc_wr_addr = addr_q[head];
  assign dc_wr_data = data_q[head];

  a_r4_store_complete_at_retire: assert property (@(posedge clk) disable iff (!rst_n)
    dc_wr_en |-> (ak_q[head] && dk_q[head]));

  a_r6_resp_after_lookup: assert property (@(posedge clk) disable iff (!rst_n)
    ld_resp_valid |-> $past(ld_valid));

  a_r10_retry_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ld_resp_fwd, ld_resp_retry}));

  a_r11_flush_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
    flush_valid |=> (count <= $past(count)));

endmodule

// File: tb/lsq_fwd_queue_tb.sv
module lsq_fwd_queue_tb;
  localparam int DEPTH = 4;
  localparam int AW = 16;
  localparam int DW = 16;
  localparam int SW = 6;
  localparam int IW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic          alloc_valid = 0, alloc_is_store = 0;
  logic [SW-1:0] alloc_seq = '0;
  logic [IW-1:0] alloc_idx;
  logic          full;
  logic          sta_valid = 0, std_valid = 0, ld_valid = 0, ret_valid = 0, flush_valid = 0;
  logic [IW-1:0] sta_idx = '0, std_idx = '0, ld_idx = '0;
  logic [AW-1:0] sta_addr = '0, ld_addr = '0;
  logic [DW-1:0] std_data = '0, dc_rd_data = '0;
  logic [SW-1:0] flush_seq = '0;
  logic          dc_rd_en, ld_resp_valid, ld_resp_fwd, ld_resp_retry, dc_wr_en;
  logic [AW-1:0] dc_rd_addr, dc_wr_addr;
  logic [DW-1:0] ld_resp_data, dc_wr_data;

  lsq_fwd_queue #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .SW(SW)) u_dut (
    .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid), .alloc_is_store(alloc_is_store),
    .alloc_seq(alloc_seq), .alloc_idx(alloc_idx), .full(full),
    .sta_valid(sta_valid), .sta_idx(sta_idx), .sta_addr(sta_addr),
    .std_valid(std_valid), .std_idx(std_idx), .std_data(std_data),
    .ld_valid(ld_valid), .ld_idx(ld_idx), .ld_addr(ld_addr),
    .dc_rd_en(dc_rd_en), .dc_rd_addr(dc_rd_addr), .dc_rd_data(dc_rd_data),
    .ld_resp_valid(ld_resp_valid), .ld_resp_fwd(ld_resp_fwd), .ld_resp_retry(ld_resp_retry),
    .ld_resp_data(ld_resp_data), .ret_valid(ret_valid), .dc_wr_en(dc_wr_en),
    .dc_wr_addr(dc_wr_addr), .dc_wr_data(dc_wr_data),
    .flush_valid(flush_valid), .flush_seq(flush_seq)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_alloc(input logic is_st, input logic [SW-1:0] seq, input int exp_idx);
    chk("R2 alloc_idx", 32'(alloc_idx), 32'(exp_idx));
    alloc_valid = 1; alloc_is_store = is_st; alloc_seq = seq;
    tick();
    alloc_valid = 0;
  endtask

  task automatic st_addr(input int idx, input logic [AW-1:0] a);
    sta_valid = 1; sta_idx = IW'(idx); sta_addr = a;
    #1 chk("R3 no write on address completion", 32'(dc_wr_en), 0);
    tick();
    sta_valid = 0;
  endtask

  task automatic st_data(input int idx, input logic [DW-1:0] d);
    std_valid = 1; std_idx = IW'(idx); std_data = d;
    #1 chk("R3 no write on data completion", 32'(dc_wr_en), 0);
    tick();
    std_valid = 0;
  endtask

  task automatic st_both(input int idx, input logic [AW-1:0] a, input logic [DW-1:0] d);
    sta_valid = 1; sta_idx = IW'(idx); sta_addr = a;
    std_valid = 1; std_idx = IW'(idx); std_data = d;
    tick();
    sta_valid = 0; std_valid = 0;
    chk("R3 no write after completion", 32'(dc_wr_en), 0);
  endtask

  task automatic do_load(input string req, input int idx, input logic [AW-1:0] a,
                         input logic [DW-1:0] cache, input logic efwd,
                         input logic eretry, input logic [DW-1:0] edata);
    ld_valid = 1; ld_idx = IW'(idx); ld_addr = a;
    #1;
    chk("R5 dc_rd_en", 32'(dc_rd_en), 1);
    chk("R5 dc_rd_addr", 32'(dc_rd_addr), 32'(a));
    tick();
    ld_valid = 0; dc_rd_data = cache;
    #1;
    chk({req, " resp_valid"}, 32'(ld_resp_valid), 1);
    chk({req, " resp_fwd"}, 32'(ld_resp_fwd), 32'(efwd));
    chk({req, " resp_retry"}, 32'(ld_resp_retry), 32'(eretry));
    chk({req, " resp_data"}, 32'(ld_resp_data), 32'(edata));
    tick();
    dc_rd_data = '0;
  endtask

  task automatic do_retire(input logic ewr, input logic [AW-1:0] a, input logic [DW-1:0] d);
    ret_valid = 1;
    #1;
    chk("R4 dc_wr_en", 32'(dc_wr_en), 32'(ewr));
    if (ewr) begin
      chk("R4 dc_wr_addr", 32'(dc_wr_addr), 32'(a));
      chk("R4 dc_wr_data", 32'(dc_wr_data), 32'(d));
    end
    tick();
    ret_valid = 0;
  endtask

  // scenario: reset state (R1)
  task automatic t_reset();
    chk("R1 full", 32'(full), 0);
    chk("R1 alloc_idx", 32'(alloc_idx), 0);
    chk("R1 ld_resp_valid", 32'(ld_resp_valid), 0);
    chk("R1 dc_wr_en", 32'(dc_wr_en), 0);
  endtask

  // scenario: one store, one load; forward and miss (R3 R5 R6 R7)
  task automatic t_basic();
    do_alloc(1, 6'd1, 0);
    do_alloc(0, 6'd2, 1);
    st_addr(0, 16'h0100);
    st_data(0, 16'hAAAA);
    do_load("R7 single store", 1, 16'h0100, 16'h1111, 1, 0, 16'hAAAA);
    do_load("R6 no match", 1, 16'h0104, 16'h5555, 0, 0, 16'h5555);
    do_retire(1, 16'h0100, 16'hAAAA);
    do_retire(0, '0, '0);
  endtask

  // scenario: full queue, wrapped load, youngest older store (R2 R7 R8 R9 R4)
  task automatic t_wrap_youngest();
    do_alloc(1, 6'd3, 2);
    do_alloc(1, 6'd4, 3);
    do_alloc(0, 6'd5, 0);
    do_alloc(1, 6'd6, 1);
    chk("R2 full when all slots used", 32'(full), 1);
    do_alloc(1, 6'd7, 2);
    chk("R2 alloc ignored while full idx", 32'(alloc_idx), 2);
    chk("R2 alloc ignored while full flag", 32'(full), 1);
    st_both(2, 16'h0200, 16'h0011);
    st_both(3, 16'h0200, 16'h0022);
    st_both(1, 16'h0200, 16'h0033);
    do_load("R9 R7 wrapped youngest older", 0, 16'h0200, 16'hEEEE, 1, 0, 16'h0022);
    do_load("R6 wrapped miss", 0, 16'h0204, 16'h1234, 0, 0, 16'h1234);
    do_retire(1, 16'h0200, 16'h0011);
    chk("R4 full drops after retire", 32'(full), 0);
    do_retire(1, 16'h0200, 16'h0022);
    do_retire(0, '0, '0);
    do_retire(1, 16'h0200, 16'h0033);
  endtask

  // scenario: unknown address ignored, missing data gives retry (R8 R10)
  task automatic t_not_ready();
    do_alloc(1, 6'd10, 2);
    do_alloc(1, 6'd11, 3);
    do_alloc(0, 6'd12, 0);
    st_both(2, 16'h0300, 16'h0077);
    do_load("R8 unknown-address store skipped", 0, 16'h0300, 16'hCCCC, 1, 0, 16'h0077);
    st_addr(3, 16'h0300);
    do_load("R10 data missing", 0, 16'h0300, 16'hCCCC, 0, 1, 16'h0000);
    st_data(3, 16'h0088);
    do_load("R10 after data arrives", 0, 16'h0300, 16'hCCCC, 1, 0, 16'h0088);
    do_retire(1, 16'h0300, 16'h0077);
    do_retire(1, 16'h0300, 16'h0088);
    do_retire(0, '0, '0);
  endtask

  // scenario: flush across sequence wrap, slot reuse (R11)
  task automatic t_flush();
    do_alloc(1, 6'd62, 1);
    do_alloc(1, 6'd63, 2);
    do_alloc(1, 6'd0, 3);
    st_both(1, 16'h0400, 16'h0001);
    st_both(2, 16'h0400, 16'h0002);
    st_both(3, 16'h0400, 16'h0003);
    flush_valid = 1; flush_seq = 6'd63;
    alloc_valid = 1; alloc_is_store = 1; alloc_seq = 6'd9;
    tick();
    flush_valid = 0; alloc_valid = 0;
    chk("R11 tail after flush", 32'(alloc_idx), 3);
    chk("R11 not full after flush", 32'(full), 0);
    do_alloc(0, 6'd0, 3);
    do_load("R11 flushed store gone", 3, 16'h0400, 16'h9999, 1, 0, 16'h0002);
  endtask

  // scenario: flush and retire in one cycle (R12)
  task automatic t_flush_retire();
    do_alloc(0, 6'd1, 0);
    chk("R12 full before flush", 32'(full), 1);
    flush_valid = 1; flush_seq = 6'd0; ret_valid = 1;
    #1;
    chk("R12 retire write during flush", 32'(dc_wr_en), 1);
    chk("R12 retire write data", 32'(dc_wr_data), 32'h0001);
    tick();
    flush_valid = 0; ret_valid = 0;
    chk("R12 tail after flush+retire", 32'(alloc_idx), 0);
    chk("R12 not full after flush+retire", 32'(full), 0);
    do_load("R12 forward after flush+retire", 3, 16'h0400, 16'h7777, 1, 0, 16'h0002);
    do_retire(1, 16'h0400, 16'h0002);
    do_retire(0, '0, '0);
    chk("R12 drained tail", 32'(alloc_idx), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_basic();
    t_wrap_youngest();
    t_not_ready();
    t_flush();
    t_flush_retire();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

endmodule